// File: doc/BRIEF.md
# Dual-Bank Interrupting GPIO Port

A 32-pin general-purpose I/O port that sits on a 32-bit register bus. The bus also accepts byte and halfword writes and reads. Each pin can act as an input or an output. An input pin can raise an event on a rising edge, on a falling edge, or when it changes to a high or low level that is being watched. Every event sets the pin's bit in two separate status registers at once. Each status register has its own enable register and its own interrupt line, so two consumers can take and clear the same pin events without affecting each other.

Set-only and clear-only alias addresses give single-write updates of the enables, the wakeup mask and the output data. A configuration register gates a one-cycle wakeup request and carries a soft-reset command. Debounce enable and debounce time are kept as plain storage, because the block does no debouncing itself.

Top module: `gpio_dual_irq`

## Requirements
- R1: After reset the block holds these values: control (0x30) reads 2, output enable (0x34) reads all ones, and both status registers, both enables, the wakeup mask, all four detect registers, both debounce registers and data out read 0. Address 0x14 always reads 1, and address 0x00 reads the `REV_ID` parameter.
- R2: A pin is an input when its output-enable bit is 1. When an input pin's sampled level changes, it raises an event if it rose and its rising-detect bit (0x48) is set, or if it fell and its falling-detect bit (0x4C) is set. An event sets the pin's bit in both status registers (0x18 and 0x28) on the clock edge that samples the change. Pins that are outputs never set status bits.
- R3: When an input pin changes to high and its level-high bit (0x44) is set, it raises an event. When it changes to low and its level-low bit (0x40) is set, it also raises an event.
- R4: `irq_a` is high exactly when some bit is set in both status1 (0x18) and enable1 (0x1C). `irq_b` works the same way from status2 (0x28) and enable2 (0x2C). An enable write is reflected on the interrupt line in the cycle after the write.
- R5: Writing a status register clears the bits written as 1 and leaves the other bank alone. If any bit was cleared, every input pin whose current level matches its level-high or level-low bit is set again in that bank.
- R6: A write to output enable (0x34), to level-low (0x40) or to level-high (0x44) sets, in both status registers, every input pin whose current level matches its level bits.
- R7: Alias addresses act on a target register: enable1 clear 0x60 / set 0x64, enable2 clear 0x70 / set 0x74, wakeup mask (0x20) clear 0x80 / set 0x84, data out (0x3C) clear 0x90 / set 0x94. Each 1 written clears or sets the matching target bit, and reading an alias returns its target. `pin_out` shows data out and `pin_oe_n` shows output enable, and data out changes only on a bus write.
- R8: `wake_req` pulses high for one cycle, on the edge that records an event, only when config (0x10) bit 2 is set, config bits [4:3] are not zero, and the event pin's wakeup-mask bit is set.
- R9: Writing config with bit 1 set performs a soft reset. All registers return to their R1 values except data out and the sampled inputs. Config then stores the written value ANDed with 0x1D. `idle_bad` is high while the stored config bits [4:3] equal 3.
- R10: `bus_size` selects the access width: 0 for a byte, 1 for a halfword, 2 or 3 for a word. The data sits in the low bits of `bus_wdata`. A sub-word write places it at byte lane `bus_addr[1:0]`. For an ordinary register the other lanes keep their contents. For a status or alias register the other lanes count as zero.
- R11: `bus_rdata` is the addressed 32-bit register shifted right by 8 times `bus_addr[1:0]`. Unmapped addresses read 0.
- R12: Writes to 0x00, 0x14 and data in (0x38) have no effect. Data in reads the pin levels sampled on the last clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address |
| bus_size | input | 2 | Access width: 0 byte, 1 halfword, 2 or 3 word |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, combinational from address |
| pin_in | input | 32 | Pin levels, synchronous to clk |
| pin_out | output | 32 | Output data |
| pin_oe_n | output | 32 | Direction, 1 = input |
| irq_a | output | 1 | Interrupt line of bank 1 |
| irq_b | output | 1 | Interrupt line of bank 2 |
| wake_req | output | 1 | One-cycle wakeup request |
| idle_bad | output | 1 | Stored idle-mode field is 3 |

## Verification
The checks assume that `pin_in` is already synchronous to `clk` and that every bus write lasts exactly one cycle with stable address, size and data. The stimulus drives all inputs on the falling edge and holds `bus_wr` high for one cycle per write. Pin changes are applied in cycles with no bus write, so events and register writes never collide. The rule that the two banks stay equal assumes only status writes can make them differ, so the bench makes every divergence through a status clear.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned CFG_W  = 5;
    localparam int unsigned CTRL_W = 3;
    localparam int unsigned DBT_W  = 8;

    localparam logic [CFG_W-1:0]  CFG_KEEP   = 5'h1D;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 3'd2;

    localparam logic [7:0] A_REV     = 8'h00;
    localparam logic [7:0] A_CFG     = 8'h10;
    localparam logic [7:0] A_SST     = 8'h14;
    localparam logic [7:0] A_STAT1   = 8'h18;
    localparam logic [7:0] A_EN1     = 8'h1C;
    localparam logic [7:0] A_WU      = 8'h20;
    localparam logic [7:0] A_STAT2   = 8'h28;
    localparam logic [7:0] A_EN2     = 8'h2C;
    localparam logic [7:0] A_CTRL    = 8'h30;
    localparam logic [7:0] A_OE      = 8'h34;
    localparam logic [7:0] A_DIN     = 8'h38;
    localparam logic [7:0] A_DOUT    = 8'h3C;
    localparam logic [7:0] A_LVLLO   = 8'h40;
    localparam logic [7:0] A_LVLHI   = 8'h44;
    localparam logic [7:0] A_RISE    = 8'h48;
    localparam logic [7:0] A_FALL    = 8'h4C;
    localparam logic [7:0] A_DBEN    = 8'h50;
    localparam logic [7:0] A_DBT     = 8'h54;
    localparam logic [7:0] A_EN1_CLR = 8'h60;
    localparam logic [7:0] A_EN1_SET = 8'h64;
    localparam logic [7:0] A_EN2_CLR = 8'h70;
    localparam logic [7:0] A_EN2_SET = 8'h74;
    localparam logic [7:0] A_WU_CLR  = 8'h80;
    localparam logic [7:0] A_WU_SET  = 8'h84;
    localparam logic [7:0] A_DO_CLR  = 8'h90;
    localparam logic [7:0] A_DO_SET  = 8'h94;

    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic [CTRL_W-1:0] ctrl;
        logic [REG_W-1:0]  stat1;
        logic [REG_W-1:0]  stat2;
        logic [REG_W-1:0]  en1;
        logic [REG_W-1:0]  en2;
        logic [REG_W-1:0]  wu;
        logic [REG_W-1:0]  oe;
        logic [REG_W-1:0]  dout;
        logic [REG_W-1:0]  lvl_lo;
        logic [REG_W-1:0]  lvl_hi;
        logic [REG_W-1:0]  rise;
        logic [REG_W-1:0]  fall;
        logic [REG_W-1:0]  db_en;
        logic [DBT_W-1:0]  db_t;
        logic [REG_W-1:0]  din;
        logic              wake;
    } gpio_state_t;

    // Returns s with every module register at its reset value; dout and din kept.
    function automatic gpio_state_t module_defaults(gpio_state_t s);
        gpio_state_t r;
        r        = '0;
        r.ctrl   = CTRL_RESET;
        r.oe     = '1;
        r.dout   = s.dout;
        r.din    = s.din;
        return r;
    endfunction
endpackage

// File: rtl/gpio_lane_merge.sv
module gpio_lane_merge #(
    parameter int unsigned W = 32
) (
    input  logic [1:0]   lane,
    input  logic [1:0]   size,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cur,
    output logic [W-1:0] raw,
    output logic [W-1:0] merged
);
    localparam int unsigned SHW = $clog2(W);

    logic [W-1:0]   keep;
    logic [SHW-1:0] sh;

    always_comb begin
        case (size)
            2'd0:    keep = W'(8'hFF);
            2'd1:    keep = W'(16'hFFFF);
            default: keep = '1;
        endcase
        sh     = size[1] ? '0 : SHW'({lane, 3'b000});
        raw    = (wdata & keep) << sh;
        merged = (cur & ~(keep << sh)) | raw;
    end
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] lvl_now,
    input  logic [W-1:0] lvl_prev,
    input  logic [W-1:0] is_in,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] hi_en,
    input  logic [W-1:0] lo_en,
    output logic [W-1:0] evt,
    output logic [W-1:0] lvl_hit
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic edge_en;
        assign lvl_hit[i] = is_in[i] & (lvl_now[i] ? hi_en[i] : lo_en[i]);
        assign edge_en    = lvl_now[i] ? rise_en[i] : fall_en[i];
        assign evt[i]     = (lvl_now[i] ^ lvl_prev[i]) &
                            (lvl_hit[i] | (is_in[i] & edge_en));
    end
endmodule

// File: rtl/gpio_dual_irq.sv
module gpio_dual_irq
    import gpio_dual_pkg::*;
#(
    parameter logic [REG_W-1:0] REV_ID = 32'h0000_0031
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [1:0]       bus_size,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic [REG_W-1:0] pin_in,
    output logic [REG_W-1:0] pin_out,
    output logic [REG_W-1:0] pin_oe_n,
    output logic             irq_a,
    output logic             irq_b,
    output logic             wake_req,
    output logic             idle_bad
);
    gpio_state_t      st_q, st_w, st_d;
    logic [7:0]       word_a;
    logic [REG_W-1:0] cur_word, wr_raw, wr_mrg, evt, lvl_hit;
    logic             resc1, resc2;

    assign word_a = {bus_addr[7:2], 2'b00};

    // Read mux: full word of the addressed register.
    always_comb begin
        case (word_a)
            A_REV:                        cur_word = REV_ID;
            A_CFG:                        cur_word = REG_W'(st_q.cfg);
            A_SST:                        cur_word = REG_W'(1);
            A_STAT1:                      cur_word = st_q.stat1;
            A_EN1, A_EN1_CLR, A_EN1_SET:  cur_word = st_q.en1;
            A_WU, A_WU_CLR, A_WU_SET:     cur_word = st_q.wu;
            A_STAT2:                      cur_word = st_q.stat2;
            A_EN2, A_EN2_CLR, A_EN2_SET:  cur_word = st_q.en2;
            A_CTRL:                       cur_word = REG_W'(st_q.ctrl);
            A_OE:                         cur_word = st_q.oe;
            A_DIN:                        cur_word = st_q.din;
            A_DOUT, A_DO_CLR, A_DO_SET:   cur_word = st_q.dout;
            A_LVLLO:                      cur_word = st_q.lvl_lo;
            A_LVLHI:                      cur_word = st_q.lvl_hi;
            A_RISE:                       cur_word = st_q.rise;
            A_FALL:                       cur_word = st_q.fall;
            A_DBEN:                       cur_word = st_q.db_en;
            A_DBT:                        cur_word = REG_W'(st_q.db_t);
            default:                      cur_word = '0;
        endcase
    end

    assign bus_rdata = cur_word >> {bus_addr[1:0], 3'b000};

    gpio_lane_merge #(.W(REG_W)) u_merge (
        .lane   (bus_addr[1:0]),
        .size   (bus_size),
        .wdata  (bus_wdata),
        .cur    (cur_word),
        .raw    (wr_raw),
        .merged (wr_mrg)
    );

    // Stage 1: register writes.
    always_comb begin
        st_w  = st_q;
        resc1 = 1'b0;
        resc2 = 1'b0;
        if (bus_wr) begin
            case (word_a)
                A_CFG: begin
                    if (wr_mrg[1]) st_w = module_defaults(st_q);
                    st_w.cfg = wr_mrg[CFG_W-1:0] & CFG_KEEP;
                end
                A_STAT1: begin
                    st_w.stat1 = st_q.stat1 & ~wr_raw;
                    resc1      = |(st_q.stat1 & wr_raw);
                end
                A_STAT2: begin
                    st_w.stat2 = st_q.stat2 & ~wr_raw;
                    resc2      = |(st_q.stat2 & wr_raw);
                end
                A_EN1:     st_w.en1  = wr_mrg;
                A_EN2:     st_w.en2  = wr_mrg;
                A_WU:      st_w.wu   = wr_mrg;
                A_CTRL:    st_w.ctrl = wr_mrg[CTRL_W-1:0];
                A_OE: begin
                    st_w.oe = wr_mrg;
                    resc1   = 1'b1;
                    resc2   = 1'b1;
                end
                A_DOUT:    st_w.dout = wr_mrg;
                A_LVLLO: begin
                    st_w.lvl_lo = wr_mrg;
                    resc1       = 1'b1;
                    resc2       = 1'b1;
                end
                A_LVLHI: begin
                    st_w.lvl_hi = wr_mrg;
                    resc1       = 1'b1;
                    resc2       = 1'b1;
                end
                A_RISE:    st_w.rise  = wr_mrg;
                A_FALL:    st_w.fall  = wr_mrg;
                A_DBEN:    st_w.db_en = wr_mrg;
                A_DBT:     st_w.db_t  = wr_mrg[DBT_W-1:0];
                A_EN1_CLR: st_w.en1  = st_q.en1 & ~wr_raw;
                A_EN1_SET: st_w.en1  = st_q.en1 | wr_raw;
                A_EN2_CLR: st_w.en2  = st_q.en2 & ~wr_raw;
                A_EN2_SET: st_w.en2  = st_q.en2 | wr_raw;
                A_WU_CLR:  st_w.wu   = st_q.wu & ~wr_raw;
                A_WU_SET:  st_w.wu   = st_q.wu | wr_raw;
                A_DO_CLR:  st_w.dout = st_q.dout & ~wr_raw;
                A_DO_SET:  st_w.dout = st_q.dout | wr_raw;
                default:   ;
            endcase
        end
    end

    gpio_event_detect #(.W(REG_W)) u_detect (
        .lvl_now  (pin_in),
        .lvl_prev (st_q.din),
        .is_in    (st_w.oe),
        .rise_en  (st_w.rise),
        .fall_en  (st_w.fall),
        .hi_en    (st_w.lvl_hi),
        .lo_en    (st_w.lvl_lo),
        .evt      (evt),
        .lvl_hit  (lvl_hit)
    );

    // Stage 2: events, level rescans, wakeup, input sampling.
    always_comb begin
        st_d       = st_w;
        st_d.stat1 = st_w.stat1 | evt | (resc1 ? lvl_hit : '0);
        st_d.stat2 = st_w.stat2 | evt | (resc2 ? lvl_hit : '0);
        st_d.wake  = (|(evt & st_q.wu)) & st_q.cfg[2] & (|st_q.cfg[4:3]);
        st_d.din   = pin_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= module_defaults('0);
        else        st_q <= st_d;
    end

    assign pin_out  = st_q.dout;
    assign pin_oe_n = st_q.oe;
    assign irq_a    = |(st_q.stat1 & st_q.en1);
    assign irq_b    = |(st_q.stat2 & st_q.en2);
    assign wake_req = st_q.wake;
    assign idle_bad = (st_q.cfg[4:3] == 2'b11);
endmodule

// File: rtl/gpio_dual_irq_chk.sv
module gpio_dual_irq_chk
    import gpio_dual_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic [1:0]       bus_size,
    input logic [REG_W-1:0] bus_rdata,
    input logic [REG_W-1:0] pin_out,
    input logic             wake_req,
    input gpio_state_t      st
);
    logic stat_wr;
    assign stat_wr = bus_wr && (bus_addr[7:2] == A_STAT1[7:2] || bus_addr[7:2] == A_STAT2[7:2]);

    // R2: newly set status bits belong to input pins only
    assert_status_input_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st.stat1 & ~$past(st.stat1) & ~st.oe) == '0));

    // R2 / R5: the banks only diverge through a status write
    assert_banks_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_wr && st.stat1 == st.stat2) |=> (st.stat1 == st.stat2));

    assert_wake_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(st.cfg[2] && (st.cfg[4:3] != 2'b00)));

    assert_sysstatus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_SST && bus_size == 2'd2) |-> (bus_rdata == REG_W'(1)));

    assert_dout_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(pin_out));
endmodule

bind gpio_dual_irq gpio_dual_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .wake_req  (wake_req),
    .st        (st_q)
);

// File: tb/gpio_dual_irq_test.sv
module gpio_dual_irq_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] REV = 32'h0000_0031;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe_n;
    logic        irq_a, irq_b, wake_req, idle_bad;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_dual_irq #(.REV_ID(REV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe_n(pin_oe_n),
        .irq_a(irq_a), .irq_b(irq_b), .wake_req(wake_req), .idle_bad(idle_bad)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [1:0] sz,
                         input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; bus_size = sz;
        #1 chk(req, bus_rdata, exp);
    endtask

    task automatic pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rdchk("R1 ctrl", 8'h30, 2, 32'd2);
        rdchk("R1 oe", 8'h34, 2, 32'hFFFF_FFFF);
        rdchk("R1 status1", 8'h18, 2, 0);
        rdchk("R1 rise", 8'h48, 2, 0);
        rdchk("R1 sysstatus", 8'h14, 2, 32'd1);
        rdchk("R1 revision", 8'h00, 2, REV);
        chk("R1 pin_out", pin_out, 0);
    endtask

    task automatic t_edges;
        wr(8'h48, 2, 32'h1);
        wr(8'h4C, 2, 32'h2);
        pins(32'h3);
        rdchk("R2 rise status1", 8'h18, 2, 32'h1);
        rdchk("R2 rise status2", 8'h28, 2, 32'h1);
        pins(32'h0);
        rdchk("R2 fall status1", 8'h18, 2, 32'h3);
        wr(8'h34, 2, 32'hFFFF_FFFB);
        chk("R7 pin_oe_n", pin_oe_n, 32'hFFFF_FFFB);
        wr(8'h48, 2, 32'h5);
        pins(32'h4);
        rdchk("R2 output pin ignored", 8'h18, 2, 32'h3);
        wr(8'h18, 2, 32'hFFFF_FFFF);
        wr(8'h28, 2, 32'hFFFF_FFFF);
        wr(8'h34, 2, 32'hFFFF_FFFF);
        wr(8'h48, 2, 0);
        wr(8'h4C, 2, 0);
        pins(0);
    endtask

    task automatic t_levels;
        wr(8'h44, 2, 32'h10);
        pins(32'h10);
        rdchk("R3 level high event", 8'h18, 2, 32'h10);
        wr(8'h18, 2, 32'h10);
        rdchk("R5 level re-asserts", 8'h18, 2, 32'h10);
        pins(0);
        wr(8'h18, 2, 32'h10);
        rdchk("R5 cleared once low", 8'h18, 2, 0);
        rdchk("R5 other bank kept", 8'h28, 2, 32'h10);
        wr(8'h28, 2, 32'h10);
        wr(8'h44, 2, 0);
    endtask

    task automatic t_rescan;
        wr(8'h40, 2, 32'h100);
        rdchk("R6 rescan status1", 8'h18, 2, 32'h100);
        rdchk("R6 rescan status2", 8'h28, 2, 32'h100);
        wr(8'h40, 2, 0);
        wr(8'h18, 2, 32'h100);
        wr(8'h28, 2, 32'h100);
        rdchk("R6 cleared", 8'h18, 2, 0);
    endtask

    task automatic t_irq;
        wr(8'h48, 2, 32'h20);
        pins(32'h20);
        chk("R4 irq_a masked", irq_a, 0);
        chk("R4 irq_b masked", irq_b, 0);
        wr(8'h2C, 2, 32'h20);
        chk("R4 irq_b on", irq_b, 1);
        chk("R4 irq_a still off", irq_a, 0);
        wr(8'h28, 2, 32'h20);
        chk("R4 irq_b after clear", irq_b, 0);
        wr(8'h64, 2, 32'h20);
        chk("R4 irq_a via set alias", irq_a, 1);
        rdchk("R7 enable1", 8'h1C, 2, 32'h20);
        rdchk("R7 alias reads target", 8'h60, 2, 32'h20);
        wr(8'h60, 2, 32'h20);
        chk("R4 irq_a via clear alias", irq_a, 0);
        wr(8'h18, 2, 32'h20);
        wr(8'h48, 2, 0);
        wr(8'h2C, 2, 0);
        pins(0);
    endtask

    task automatic t_alias;
        wr(8'h3C, 2, 32'hF0F0);
        wr(8'h94, 2, 32'h000F);
        wr(8'h90, 2, 32'h00F0);
        chk("R7 data out set/clear", pin_out, 32'hF00F);
        rdchk("R7 data out alias read", 8'h94, 2, 32'hF00F);
        wr(8'h84, 2, 32'h3);
        wr(8'h80, 2, 32'h1);
        rdchk("R7 wakeup mask", 8'h20, 2, 32'h2);
        wr(8'h74, 2, 32'h8);
        rdchk("R7 enable2 set", 8'h2C, 2, 32'h8);
        wr(8'h70, 2, 32'h8);
        rdchk("R7 enable2 clear", 8'h2C, 2, 0);
    endtask

    task automatic t_wake;
        wr(8'h48, 2, 32'h3);
        wr(8'h10, 2, 32'h0C);
        rdchk("R9 config read", 8'h10, 2, 32'h0C);
        pins(32'h2);
        chk("R8 wake pulse", wake_req, 1);
        @(negedge clk);
        chk("R8 wake one cycle", wake_req, 0);
        wr(8'h10, 2, 32'h04);
        pins(0);
        pins(32'h2);
        chk("R8 no wake idle 0", wake_req, 0);
        wr(8'h10, 2, 32'h0C);
        pins(0);
        pins(32'h1);
        chk("R8 no wake unmasked pin", wake_req, 0);
        wr(8'h18, 2, 32'hFFFF_FFFF);
        wr(8'h28, 2, 32'hFFFF_FFFF);
    endtask

    task automatic t_soft_reset;
        wr(8'h30, 2, 32'hFF);
        rdchk("R9 ctrl 3 bits", 8'h30, 2, 32'h7);
        wr(8'h10, 2, 32'h1A);
        rdchk("R9 config masked", 8'h10, 2, 32'h18);
        chk("R9 idle_bad", idle_bad, 1);
        rdchk("R9 rise reset", 8'h48, 2, 0);
        rdchk("R9 ctrl reset", 8'h30, 2, 32'd2);
        rdchk("R9 wakeup reset", 8'h20, 2, 0);
        chk("R9 data out kept", pin_out, 32'hF00F);
        wr(8'h10, 2, 0);
        chk("R9 idle_bad clear", idle_bad, 0);
        pins(0);
    endtask

    task automatic t_subword;
        wr(8'h48, 2, 32'h1122_3344);
        wr(8'h49, 0, 32'hAA);
        rdchk("R10 byte merge", 8'h48, 2, 32'h1122_AA44);
        wr(8'h4A, 1, 32'hBEEF);
        rdchk("R10 half merge", 8'h48, 2, 32'hBEEF_AA44);
        rdchk("R11 byte read", 8'h4B, 0, 32'h0000_00BE);
        rdchk("R11 half read", 8'h4A, 1, 32'h0000_BEEF);
        pins(32'hBEEF_AA44);
        wr(8'h1A, 1, 32'h00FF);
        rdchk("R10 status lanes zero", 8'h18, 2, 32'hBE00_AA44);
        rdchk("R10 other bank", 8'h28, 2, 32'hBEEF_AA44);
        wr(8'h95, 0, 32'h01);
        chk("R10 alias byte", pin_out, 32'hF10F);
        wr(8'h48, 2, 0);
        pins(0);
        wr(8'h18, 2, 32'hFFFF_FFFF);
        wr(8'h28, 2, 32'hFFFF_FFFF);
    endtask

    task automatic t_readonly;
        wr(8'h00, 2, 32'hFFFF_FFFF);
        wr(8'h14, 2, 32'h0);
        wr(8'h38, 2, 32'hFFFF_FFFF);
        pins(32'h5A);
        rdchk("R12 revision kept", 8'h00, 2, REV);
        rdchk("R12 sysstatus kept", 8'h14, 2, 32'd1);
        rdchk("R12 data in", 8'h38, 2, 32'h5A);
        rdchk("R11 unmapped", 8'h58, 2, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_edges;
        t_levels;
        t_rescan;
        t_irq;
        t_alias;
        t_wake;
        t_soft_reset;
        t_subword;
        t_readonly;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule